// File: doc/BRIEF.md
# Byte-Level I2C Target Engine with Host Status Flags

This block is a 7-bit-address I2C target that a host processor services one byte at a time. It samples the bus clock and data lines through synchronizers, finds START and STOP conditions, compares the address byte with a programmed own address (or the general-call address), and answers with ACK or NACK by pulling the data line low through an open-drain enable. When a controller reads, the engine shifts out, MSB first, the byte the host placed in the data port. When a controller writes, each received byte is captured into that same port.

The host sees five byte-wide registers: control (offset 0), own address (offset 1), status (offset 2), interrupt enable (offset 3, same bit layout as status) and the data port (offset 4). Status flags are sticky and are cleared by writing 0 to them. A single interrupt line is raised while any status flag has its enable bit set. While a byte event waits for service, the engine stretches the bus clock until the host touches the data port.

Top module: `i2c_tgt_core`

## Requirements
- R1: After reset the status (offset 2), control (offset 0) and interrupt output are all zero and neither open-drain enable (`sclOe`, `sdaOe`) is active.
- R2: With control bit 2 (enable) set and a nonzero own address, an address byte whose upper seven bits equal the own address is ACKed and sets status bit 0; a different address, own address 0, or enable cleared gives no ACK and no status bit.
- R3: The address byte 0x00 (general call, write) is ACKed only when control bits 2 and 1 are both set, and then sets status bits 6 and 0; 0x01 is never ACKed as a general call.
- R4: In a write transfer each data byte is ACKed, captured into the data port (offset 4) and sets status bit 1.
- R5: While control bit 0 is set, a received data byte is answered with NACK (the byte is still captured and status bit 1 still sets).
- R6: A read-direction match sets status bits 5 and 3; the byte the host writes to the data port is sent MSB first; after each sent byte status bit 2 sets, and if the controller ACKs, status bit 3 sets again to request the next byte.
- R7: After the ACK slot of a received byte, or after a read-direction address or controller ACK, the engine holds SCL low (`sclOe`=1) until the host reads or writes the data port, and releases it the next cycle.
- R8: Status bit 4 sets on every STOP on the bus, also for transfers addressed to another target.
- R9: A write to the status register clears each bit written as 0 and keeps each bit written as 1.
- R10: `irq` is high exactly when some status bit and the same bit of the interrupt-enable register (offset 3) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| sclIn | input | 1 | Sampled level of the bus clock line |
| sdaIn | input | 1 | Sampled level of the bus data line |
| sclOe | output | 1 | Pulls the clock line low when 1 (clock hold) |
| sdaOe | output | 1 | Pulls the data line low when 1 (ACK or a 0 data bit) |
| hostWr | input | 1 | Host register write strobe, one cycle |
| hostRd | input | 1 | Host register read strobe, one cycle |
| hostAddr | input | 3 | Host register offset |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Read data of the register at `hostAddr` |
| irq | output | 1 | Interrupt request |

## Verification
The address stage is driven with a table of own-address, control and address-byte combinations: an exact write match, a read match, a neighbouring address, a disabled interface, own address zero, and general call with and without its enable and with the read bit set; each separates the comparator, the enable gating and the general-call path. Directed transfers then send two-byte writes (telling capture and clock hold apart from the ACK logic), a write under forced NACK, a two-byte read ended by a controller NACK, and a transaction for a foreign address that only the stop flag may record. Status clearing is tried with a single-bit zero mask and an all-zero write, and the interrupt with a matching and a non-matching enable.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  // host register offsets
  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_OWN  = 3'd1;
  localparam logic [2:0] OFS_STAT = 3'd2;
  localparam logic [2:0] OFS_IEN  = 3'd3;
  localparam logic [2:0] OFS_DATA = 3'd4;

  // control bits
  localparam int CTRL_W  = 4;
  localparam int CB_NACK = 0;
  localparam int CB_GCEN = 1;
  localparam int CB_EN   = 2;

  // status / enable bits
  localparam int STAT_W  = 7;
  localparam int SB_ADDR = 0;
  localparam int SB_RXD  = 1;
  localparam int SB_TXD  = 2;
  localparam int SB_TXE  = 3;
  localparam int SB_STOP = 4;
  localparam int SB_DIR  = 5;
  localparam int SB_GC   = 6;

  // control -> datapath strobes
  typedef struct packed {
    logic clrCnt;
    logic loadTx;
    logic shiftTx;
    logic txMode;
    logic ackDrive;
  } dpCtl_t;

  // datapath -> control events
  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
    logic sdaBit;
  } dpEvt_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_RX, S_TX, S_AACK, S_ACKBIT, S_TACK, S_HOLD
  } tgtState_t;
endpackage

// File: rtl/i2c_tgt_datapath.sv
module i2c_tgt_datapath
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] txByte,
  output dpEvt_t            evt,
  output logic [DATA_W-2:0] rxShift,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              sdaOe
);
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclP, sdaP;
  logic [DATA_W-1:0] txShift;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (rst) begin
          sclSync[0] <= 1'b1;
          sdaSync[0] <= 1'b1;
        end else begin
          sclSync[0] <= sclIn;
          sdaSync[0] <= sdaIn;
        end
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (rst) begin
          sclSync[g] <= 1'b1;
          sdaSync[g] <= 1'b1;
        end else begin
          sclSync[g] <= sclSync[g-1];
          sdaSync[g] <= sdaSync[g-1];
        end
      end
    end
  end

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclS;
      sdaP <= sdaS;
    end
  end

  assign evt.sclRise = sclS & ~sclP;
  assign evt.sclFall = ~sclS & sclP;
  assign evt.start   = sclS & sclP & sdaP & ~sdaS;
  assign evt.stop    = sclS & sclP & ~sdaP & sdaS;
  assign evt.sdaBit  = sdaS;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else begin
      if (ctl.clrCnt) bitCnt <= '0;
      else if (evt.sclRise) bitCnt <= bitCnt + 1'b1;
      if (evt.sclRise) rxShift <= {rxShift[DATA_W-3:0], sdaS};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) txShift <= '0;
    else if (ctl.loadTx) txShift <= txByte;
    else if (ctl.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b0};
  end

  assign sdaOe = ctl.ackDrive | (ctl.txMode & ~txShift[DATA_W-1]);

  // R6: a sent bit never changes while the sampled clock stays high
  a_r6_tx_stable: assert property (@(posedge clk) disable iff (rst)
    (ctl.txMode && $past(ctl.txMode) && sclS && sclP) |-> $stable(sdaOe));
endmodule

// File: rtl/i2c_tgt_control.sv
module i2c_tgt_control
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W  = $clog2(DATA_W + 1),
  localparam int ADDR_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  dpEvt_t            evt,
  input  logic [DATA_W-2:0] rxShift,
  input  logic [CNT_W-1:0]  bitCnt,
  output dpCtl_t            ctl,
  output logic [DATA_W-1:0] txByte,
  output logic              sclOe,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [2:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              irq
);
  tgtState_t st, stNxt;
  logic [CTRL_W-1:0] ctrlReg;
  logic [ADDR_W-1:0] ownAddr;
  logic [STAT_W-1:0] status, statNxt, ienReg, setMask;
  logic [DATA_W-1:0] dataReg, dataNxt, fullByte;
  logic rdDir, rdNxt, ackOk, ackNxt, ackDrv, driveNxt;
  logic pendRx, pendTx, pRxNxt, pTxNxt, matchEvt;
  logic dataAccess, dataWr, statWr, lastRise, addrHit, gcHit, pendAny;

  assign dataAccess = (hostWr | hostRd) && hostAddr == OFS_DATA;
  assign dataWr     = hostWr && hostAddr == OFS_DATA;
  assign statWr     = hostWr && hostAddr == OFS_STAT;
  assign fullByte   = {rxShift, evt.sdaBit};
  assign lastRise   = evt.sclRise && bitCnt == CNT_W'(DATA_W - 1);
  assign addrHit    = ctrlReg[CB_EN] && ownAddr != '0 && fullByte[DATA_W-1:1] == ownAddr;
  assign gcHit      = ctrlReg[CB_EN] && ctrlReg[CB_GCEN] && fullByte == '0;
  assign pendAny    = (pendRx | pendTx) && !dataAccess;
  assign txByte     = dataWr ? hostWdata : dataReg;

  always_comb begin
    stNxt = st; setMask = '0; matchEvt = 1'b0;
    rdNxt = rdDir; ackNxt = ackOk; driveNxt = ackDrv;
    pRxNxt = pendRx & ~dataAccess; pTxNxt = pendTx & ~dataAccess;
    dataNxt = dataWr ? hostWdata : dataReg;
    ctl = '0;
    if (evt.stop) begin
      stNxt = S_IDLE; driveNxt = 1'b0; setMask[SB_STOP] = 1'b1;
    end else if (evt.start) begin
      stNxt = S_ADDR; driveNxt = 1'b0; ctl.clrCnt = 1'b1;
      pRxNxt = 1'b0; pTxNxt = 1'b0;
    end else begin
      case (st)
        S_ADDR: if (lastRise) begin
          if (addrHit || gcHit) begin
            matchEvt = 1'b1; rdNxt = fullByte[0]; ackNxt = 1'b1; stNxt = S_AACK;
            setMask[SB_ADDR] = 1'b1; setMask[SB_GC] = gcHit;
            if (fullByte[0]) begin setMask[SB_TXE] = 1'b1; pTxNxt = 1'b1; end
          end else stNxt = S_IDLE;
        end
        S_RX: if (lastRise) begin
          dataNxt = fullByte; setMask[SB_RXD] = 1'b1; pRxNxt = 1'b1;
          ackNxt = !ctrlReg[CB_NACK]; stNxt = S_AACK;
        end
        S_AACK: if (evt.sclFall) begin driveNxt = ackOk; stNxt = S_ACKBIT; end
        S_TX: if (evt.sclFall) begin
          if (bitCnt == CNT_W'(DATA_W)) stNxt = S_TACK;
          else ctl.shiftTx = 1'b1;
        end
        S_TACK: if (evt.sclRise) begin
          ackNxt = !evt.sdaBit; setMask[SB_TXD] = 1'b1;
          if (!evt.sdaBit) begin setMask[SB_TXE] = 1'b1; pTxNxt = 1'b1; end
        end
        S_HOLD: if (dataAccess) begin
          if (rdDir) begin ctl.loadTx = 1'b1; stNxt = S_TX; end
          else stNxt = S_RX;
        end
        default: ;
      endcase
      // end of an acknowledge slot: stop, hold the clock, or move on
      if ((st == S_ACKBIT || st == S_TACK) && evt.sclFall) begin
        driveNxt = 1'b0; ctl.clrCnt = 1'b1;
        if (!ackOk) stNxt = S_IDLE;
        else if (pendAny) stNxt = S_HOLD;
        else if (rdDir) begin ctl.loadTx = 1'b1; stNxt = S_TX; end
        else stNxt = S_RX;
      end
    end
    ctl.txMode   = (st == S_TX);
    ctl.ackDrive = ackDrv;
    statNxt = (statWr ? (status & hostWdata[STAT_W-1:0]) : status) | setMask;
    if (matchEvt) statNxt[SB_DIR] = rdNxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; ctrlReg <= '0; ownAddr <= '0; status <= '0; ienReg <= '0;
      dataReg <= '0; rdDir <= 1'b0; ackOk <= 1'b0; ackDrv <= 1'b0;
      pendRx <= 1'b0; pendTx <= 1'b0;
    end else begin
      st <= stNxt; status <= statNxt; dataReg <= dataNxt;
      rdDir <= rdNxt; ackOk <= ackNxt; ackDrv <= driveNxt;
      pendRx <= pRxNxt; pendTx <= pTxNxt;
      if (hostWr && hostAddr == OFS_CTRL) ctrlReg <= hostWdata[CTRL_W-1:0];
      if (hostWr && hostAddr == OFS_OWN)  ownAddr <= hostWdata[ADDR_W-1:0];
      if (hostWr && hostAddr == OFS_IEN)  ienReg  <= hostWdata[STAT_W-1:0];
    end
  end

  assign sclOe = (st == S_HOLD);
  assign irq   = |(status & ienReg);

  always_comb begin
    case (hostAddr)
      OFS_CTRL: hostRdata = DATA_W'(ctrlReg);
      OFS_OWN:  hostRdata = DATA_W'(ownAddr);
      OFS_STAT: hostRdata = DATA_W'(status);
      OFS_IEN:  hostRdata = DATA_W'(ienReg);
      OFS_DATA: hostRdata = dataReg;
      default:  hostRdata = '0;
    endcase
  end

  // R7: a data-port access ends the clock hold on the next cycle
  a_r7_hold_release: assert property (@(posedge clk) disable iff (rst)
    (sclOe && dataAccess && !evt.start && !evt.stop) |=> !sclOe);
  // R9: an all-zero write empties the status when nothing sets a flag
  a_r9_clear_all: assert property (@(posedge clk) disable iff (rst)
    (statWr && hostWdata == '0 && setMask == '0 && !matchEvt) |=> status == '0);
  // R8: every detected STOP leaves the stop flag set
  a_r8_stop_flag: assert property (@(posedge clk) disable iff (rst)
    evt.stop |=> status[SB_STOP]);
  // R3: the general-call flag only rises while its enable is on
  a_r3_gc_enabled: assert property (@(posedge clk) disable iff (rst)
    $rose(status[SB_GC]) |-> $past(ctrlReg[CB_GCEN]));
endmodule

// File: rtl/i2c_tgt_core.sv
module i2c_tgt_core
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [2:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              irq
);
  dpCtl_t            ctl;
  dpEvt_t            evt;
  logic [DATA_W-2:0] rxShift;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] txByte;

  i2c_tgt_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst(rst), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .txByte(txByte), .evt(evt), .rxShift(rxShift), .bitCnt(bitCnt), .sdaOe(sdaOe)
  );

  i2c_tgt_control #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst(rst), .evt(evt), .rxShift(rxShift), .bitCnt(bitCnt),
    .ctl(ctl), .txByte(txByte), .sclOe(sclOe), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata), .irq(irq)
  );
endmodule

// File: tb/i2c_tgt_core_bench.sv
module i2c_tgt_core_bench;
  localparam int H = 10;
  logic clk = 1'b0, rst = 1'b1;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic hostWr = 1'b0, hostRd = 1'b0;
  logic [2:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic sclOe, sdaOe, irq, sclLine, sdaLine;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  assign sclLine = sclDrv & ~sclOe;
  assign sdaLine = sdaDrv & ~sdaOe;

  i2c_tgt_core u_i2c_tgt_core (
    .clk(clk), .rst(rst), .sclIn(sclLine), .sdaIn(sdaLine), .sclOe(sclOe), .sdaOe(sdaOe),
    .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .irq(irq)
  );

  // {ownAddr, ctrl, addressByte, expAck, expStatus}
  localparam logic [39:0] VEC [7] = '{
    {8'h2A, 8'h04, 8'h54, 8'h01, 8'h01},
    {8'h2A, 8'h04, 8'h55, 8'h01, 8'h29},
    {8'h2A, 8'h04, 8'h56, 8'h00, 8'h00},
    {8'h2A, 8'h00, 8'h54, 8'h00, 8'h00},
    {8'h00, 8'h04, 8'h00, 8'h00, 8'h00},
    {8'h00, 8'h06, 8'h00, 8'h01, 8'h41},
    {8'h00, 8'h06, 8'h01, 8'h00, 8'h00}
  };

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(logic [2:0] a, logic [7:0] d);
    @(negedge clk); hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic hostRead(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); hostRd = 1'b1; hostAddr = a;
    #2 d = hostRdata;
    @(negedge clk); hostRd = 1'b0;
  endtask

  task automatic waitHigh();
    for (int g = 0; g < 5000 && !sclLine; g++) tick(1);
  endtask

  task automatic busStart();
    sdaDrv = 1'b0; tick(H); sclDrv = 1'b0; tick(H);
  endtask

  task automatic busStop();
    tick(H / 2); sdaDrv = 1'b0; tick(H / 2);
    sclDrv = 1'b1; waitHigh(); tick(H); sdaDrv = 1'b1; tick(H);
  endtask

  task automatic bitOut(logic b);
    tick(H / 2); sdaDrv = b; tick(H / 2);
    sclDrv = 1'b1; waitHigh(); tick(H); sclDrv = 1'b0;
  endtask

  task automatic bitIn(output logic b);
    tick(H / 2); sdaDrv = 1'b1; tick(H / 2);
    sclDrv = 1'b1; waitHigh(); tick(H / 2); b = sdaLine; tick(H / 2); sclDrv = 1'b0;
  endtask

  task automatic sendByte(logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bitOut(d[i]);
    bitIn(a); ack = !a;
  endtask

  task automatic recvByte(logic mAck, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bitIn(b); d[i] = b; end
    bitOut(!mAck);
  endtask

  initial begin
    logic [7:0] rd;
    logic ack;
    tick(5); rst = 1'b0; tick(5);

    // R1: reset state
    hostRead(3'd2, rd); check("R1 status", rd, 8'h00);
    hostRead(3'd0, rd); check("R1 control", rd, 8'h00);
    check("R1 irq", irq, 1'b0);
    check("R1 sclOe", sclOe, 1'b0);
    check("R1 sdaOe", sdaOe, 1'b0);

    // address-stage table: R2 (vectors 0-3), R3 (vectors 4-6)
    for (int v = 0; v < 7; v++) begin
      string tag;
      tag = (v < 4) ? "R2" : "R3";
      hostWrite(3'd1, VEC[v][39:32]);
      hostWrite(3'd0, VEC[v][31:24]);
      hostWrite(3'd2, 8'h00);
      busStart();
      sendByte(VEC[v][23:16], ack);
      tick(H);
      check($sformatf("%s ack vec%0d", tag, v), ack, VEC[v][8]);
      hostRead(3'd2, rd);
      check($sformatf("%s status vec%0d", tag, v), rd, VEC[v][7:0]);
      if (ack && VEC[v][16]) begin
        hostWrite(3'd4, 8'hFF);
        recvByte(1'b0, rd);
        check("R6 table read byte", rd, 8'hFF);
      end
      busStop();
      hostWrite(3'd2, 8'h00);
    end

    // R4/R7: two-byte write with clock hold
    hostWrite(3'd1, 8'h2A); hostWrite(3'd0, 8'h04); hostWrite(3'd2, 8'h00);
    busStart();
    sendByte(8'h54, ack);
    sendByte(8'hC3, ack);
    check("R4 data ack", ack, 1'b1);
    tick(H);
    check("R7 hold after rx", sclOe, 1'b1);
    hostRead(3'd2, rd); check("R4 status rx", rd, 8'h03);
    check("R7 hold kept by status read", sclOe, 1'b1);
    hostRead(3'd4, rd); check("R4 data port", rd, 8'hC3);
    tick(2);
    check("R7 release", sclOe, 1'b0);
    sendByte(8'h7E, ack);
    tick(H);
    hostRead(3'd4, rd); check("R4 second byte", rd, 8'h7E);
    busStop();
    hostRead(3'd2, rd); check("R8 stop own", rd, 8'h13);

    // R9 / R10
    hostWrite(3'd2, 8'hFD);
    hostRead(3'd2, rd); check("R9 clear one", rd, 8'h11);
    hostWrite(3'd3, 8'h10); tick(1);
    check("R10 irq on", irq, 1'b1);
    hostWrite(3'd3, 8'h02); tick(1);
    check("R10 irq off", irq, 1'b0);
    hostWrite(3'd3, 8'h00);
    hostWrite(3'd2, 8'h00);
    hostRead(3'd2, rd); check("R9 clear all", rd, 8'h00);

    // R5: forced NACK
    hostWrite(3'd0, 8'h05);
    busStart();
    sendByte(8'h54, ack);
    check("R5 address still acked", ack, 1'b1);
    sendByte(8'h99, ack);
    check("R5 data nacked", ack, 1'b0);
    tick(H);
    check("R5 no hold after nack", sclOe, 1'b0);
    busStop();
    hostWrite(3'd0, 8'h04);
    hostRead(3'd2, rd); check("R5 status", rd, 8'h13);
    hostWrite(3'd2, 8'h00);

    // R6: read transfer of two bytes
    busStart();
    sendByte(8'h55, ack);
    check("R6 read address ack", ack, 1'b1);
    tick(H);
    check("R7 hold on read match", sclOe, 1'b1);
    hostRead(3'd2, rd); check("R6 status match", rd, 8'h29);
    hostWrite(3'd4, 8'hA5);
    recvByte(1'b1, rd); check("R6 first byte", rd, 8'hA5);
    tick(H);
    check("R7 hold after controller ack", sclOe, 1'b1);
    hostRead(3'd2, rd); check("R6 status sent", rd, 8'h2D);
    hostWrite(3'd4, 8'h3C);
    recvByte(1'b0, rd); check("R6 second byte", rd, 8'h3C);
    busStop();
    hostWrite(3'd2, 8'h00);

    // R8: stop of a transfer for another target
    busStart();
    sendByte(8'h62, ack);
    check("R8 foreign nack", ack, 1'b0);
    busStop();
    hostRead(3'd2, rd); check("R8 stop foreign", rd, 8'h10);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule